// File: doc/BRIEF.md
# Byte-Coded Register Machine Interpreter

This block is a small multicycle engine that behaves like a simple abstract machine. The machine has four 8-bit architectural registers, named A, B, C and D. The engine takes one instruction byte at a time through a valid/ready handshake. It splits the byte into an opcode and three register selectors and reads the two source registers. It then forms either their sum or their product and writes the low byte of the result to the destination register. The product comes from an iterative shift-and-add loop, so the block contains no hardware multiplier.

The engine runs in an endless loop: fetch a byte, decode it, execute it, go back to fetch. While an instruction is in flight, `in_ready` is low and `busy` is high. A debug port reads any one register through a combinational path. The same port can load a register while the engine is idle, which is the only way to place operand values in the machine. All registers clear on a synchronous reset.

Top module: `interp_core`

## Requirements
- R1: The instruction byte holds the opcode in bits [7:6], the destination selector in bits [5:4], the first source selector in bits [3:2] and the second source selector in bits [1:0].
- R2: Opcode 00 adds the two sources and writes the result modulo 256 to the destination.
- R3: Opcode 01 multiplies the two sources and writes only the low 8 bits of the 16-bit product to the destination.
- R4: Selector codes 00, 01, 10 and 11 address registers A, B, C and D. `dbg_sel` uses the same codes, and `dbg_data` shows the addressed register in the same cycle.
- R5: Opcodes 10 and 11 consume the byte, change no register, and leave `in_ready` high in the next cycle.
- R6: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. After an ADD is accepted, `in_ready` is low for exactly one cycle, and the result is visible once `in_ready` returns.
- R7: After a MUL is accepted, `in_ready` is low for exactly 8 cycles, one per multiplier bit, and the result is visible once `in_ready` returns.
- R8: The destination may equal either source or both. Source values are the ones held at acceptance, before any write-back.
- R9: While `rst` is high at a clock edge, all four registers clear to zero, and `in_ready` is high in the next cycle.
- R10: A debug write (`dbg_we` high) loads `dbg_wdata` into the register chosen by `dbg_sel` when the engine is idle. A debug write is ignored while `busy` is high.
- R11: `busy` is always the inverse of `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte offered |
| in_ready | output | 1 | Engine can accept a byte |
| in_instr | input | 8 | Instruction byte |
| busy | output | 1 | Instruction in flight |
| dbg_sel | input | 2 | Register selector for debug read and write |
| dbg_we | input | 1 | Debug write enable, honoured only when idle |
| dbg_wdata | input | 8 | Debug write data |
| dbg_data | output | 8 | Register contents addressed by `dbg_sel` |

## Verification
Two situations are hard to reach from the ports. The first is aliasing, where the destination is also a source and the loop must keep working on the latched copies while the register itself is overwritten. The second is a debug write that arrives in the middle of a multiply. The bench produces aliasing with random selectors and with directed bytes that name the same register three times. It also raises `dbg_we` on a register that is not the destination while the 8-step loop is running, then reads every register once the engine is idle again. Operands of 0xFF and 0x80 cover wrap-around of the sum and truncation of the product.

// File: rtl/interp_pkg.sv
package interp_pkg;
   localparam int OP_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 2'b00,
      OP_MUL  = 2'b01,
      OP_IDL2 = 2'b10,
      OP_IDL3 = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      ST_FETCH = 2'b00,
      ST_ADD   = 2'b01,
      ST_MUL   = 2'b10
   } st_e;
endpackage

// File: rtl/interp_decode.sv
module interp_decode
   import interp_pkg::*;
#(
   parameter int SEL_W = 2,
   localparam int IW   = OP_W + 3*SEL_W
) (
   input  logic [IW-1:0]    instr,
   output op_e              op,
   output logic [SEL_W-1:0] dst,
   output logic [SEL_W-1:0] src_a,
   output logic [SEL_W-1:0] src_b
);
   // Opcode sits at the top, then destination, first source, second source.
   always_comb begin
      op    = op_e'(instr[IW-1 -: OP_W]);
      dst   = instr[3*SEL_W-1 -: SEL_W];
      src_a = instr[2*SEL_W-1 -: SEL_W];
      src_b = instr[SEL_W-1:0];
   end
endmodule

// File: rtl/interp_regfile.sv
module interp_regfile #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 2,
   localparam int NREG  = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [SEL_W-1:0]  rsel_b,
   output logic [DATA_W-1:0] rdata_b,
   input  logic [SEL_W-1:0]  rsel_d,
   output logic [DATA_W-1:0] rdata_d
);
   logic [DATA_W-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            regs[g] <= '0;
         else if (we && (wsel == SEL_W'(g)))
            regs[g] <= wdata;
      end
   end

   assign rdata_a = regs[rsel_a];
   assign rdata_b = regs[rsel_b];
   assign rdata_d = regs[rsel_d];
endmodule

// File: rtl/interp_mulstep.sv
module interp_mulstep #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] mcand,
   input  logic              mbit,
   output logic [DATA_W-1:0] acc_out
);
   // One step of the MSB-first loop: double the partial sum, then add the
   // multiplicand when the current multiplier bit is set. Carries beyond
   // DATA_W drop out, so only the low byte of the product survives.
   logic [DATA_W-1:0] addend;

   always_comb begin
      addend  = mbit ? mcand : '0;
      acc_out = {acc_in[DATA_W-2:0], 1'b0} + addend;
   end
endmodule

// File: rtl/interp_core.sv
module interp_core
   import interp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 2,
   localparam int IW    = OP_W + 3*SEL_W,
   localparam int STEPS = DATA_W,
   localparam int CNT_W = $clog2(STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [IW-1:0]     in_instr,
   output logic              busy,
   input  logic [SEL_W-1:0]  dbg_sel,
   input  logic              dbg_we,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic [DATA_W-1:0] dbg_data
);
   if (DATA_W < 2) begin : g_bad_width
      $error("interp_core: DATA_W must be at least 2");
   end
   if (SEL_W < 1) begin : g_bad_sel
      $error("interp_core: SEL_W must be at least 1");
   end

   st_e               state;
   op_e               dec_op;
   logic [SEL_W-1:0]  dec_dst, dec_sa, dec_sb;
   logic [SEL_W-1:0]  dst_q;
   logic [DATA_W-1:0] opa_q, opb_q, acc_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] rd_a, rd_b, step_out;
   logic              accept;
   logic              wb_we, rf_we;
   logic [DATA_W-1:0] wb_data, rf_wdata;
   logic [SEL_W-1:0]  rf_wsel;

   interp_decode #(.SEL_W(SEL_W)) i_dec (
      .instr (in_instr),
      .op    (dec_op),
      .dst   (dec_dst),
      .src_a (dec_sa),
      .src_b (dec_sb)
   );

   interp_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (rf_we),
      .wsel    (rf_wsel),
      .wdata   (rf_wdata),
      .rsel_a  (dec_sa),
      .rdata_a (rd_a),
      .rsel_b  (dec_sb),
      .rdata_b (rd_b),
      .rsel_d  (dbg_sel),
      .rdata_d (dbg_data)
   );

   interp_mulstep #(.DATA_W(DATA_W)) i_step (
      .acc_in  (acc_q),
      .mcand   (opa_q),
      .mbit    (opb_q[DATA_W-1]),
      .acc_out (step_out)
   );

   assign in_ready = (state == ST_FETCH);
   assign busy     = (state != ST_FETCH);
   assign accept   = in_valid && in_ready;

   // Write-back port: the engine owns it while busy; debug writes only when idle.
   always_comb begin
      wb_we   = (state == ST_ADD) ||
                ((state == ST_MUL) && (cnt_q == CNT_W'(1)));
      wb_data = (state == ST_ADD) ? (opa_q + opb_q) : step_out;
      if (wb_we) begin
         rf_we    = 1'b1;
         rf_wsel  = dst_q;
         rf_wdata = wb_data;
      end else begin
         rf_we    = dbg_we && (state == ST_FETCH);
         rf_wsel  = dbg_sel;
         rf_wdata = dbg_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_FETCH;
         dst_q <= '0;
         opa_q <= '0;
         opb_q <= '0;
         acc_q <= '0;
         cnt_q <= '0;
      end else begin
         unique case (state)
            ST_FETCH: begin
               if (accept) begin
                  dst_q <= dec_dst;
                  opa_q <= rd_a;
                  opb_q <= rd_b;
                  acc_q <= '0;
                  cnt_q <= CNT_W'(STEPS);
                  unique case (dec_op)
                     OP_ADD:  state <= ST_ADD;
                     OP_MUL:  state <= ST_MUL;
                     default: state <= ST_FETCH;
                  endcase
               end
            end
            ST_ADD: state <= ST_FETCH;
            ST_MUL: begin
               acc_q <= step_out;
               opb_q <= {opb_q[DATA_W-2:0], 1'b0};
               cnt_q <= cnt_q - CNT_W'(1);
               if (cnt_q == CNT_W'(1))
                  state <= ST_FETCH;
            end
            default: state <= ST_FETCH;
         endcase
      end
   end
endmodule

// File: rtl/interp_core_chk.sv
module interp_core_chk #(
   parameter int DATA_W = 8,
   parameter int IW     = 8,
   localparam int STEPS = DATA_W,
   localparam int CW    = $clog2(STEPS + 2) + 1
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          in_ready,
   input logic [IW-1:0] in_instr,
   input logic          busy
);
   logic          acc_ev;
   logic [1:0]    op_now;
   logic          was_mul;
   logic [CW-1:0] stall_cnt;

   assign acc_ev = in_valid && in_ready;
   assign op_now = in_instr[IW-1 -: 2];

   // Counts stalled cycles after each accepted byte.
   always_ff @(posedge clk) begin
      if (rst) begin
         was_mul   <= 1'b0;
         stall_cnt <= '0;
      end else if (acc_ev) begin
         was_mul   <= (op_now == 2'b01);
         stall_cnt <= '0;
      end else if (!in_ready && (stall_cnt != '1)) begin
         stall_cnt <= stall_cnt + CW'(1);
      end
   end

   AST_RESET_READY: assert property (@(posedge clk) rst |=> in_ready); // R9
   AST_ADD_ONE_STALL: assert property (@(posedge clk) disable iff (rst)
      (acc_ev && op_now == 2'b00) |=> (!in_ready ##1 in_ready)); // R6
   AST_IDLE_OP_NO_STALL: assert property (@(posedge clk) disable iff (rst)
      (acc_ev && op_now[1]) |=> in_ready); // R5
   AST_MUL_STALLS: assert property (@(posedge clk) disable iff (rst)
      (acc_ev && op_now == 2'b01) |=> !in_ready); // R7
   AST_MUL_LENGTH: assert property (@(posedge clk) disable iff (rst)
      (was_mul && $rose(in_ready)) |-> (stall_cnt == CW'(STEPS))); // R7
   AST_BUSY_INVERSE: assert property (@(posedge clk) disable iff (rst)
      busy != in_ready); // R11
endmodule

bind interp_core interp_core_chk #(.DATA_W(DATA_W), .IW(IW)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_instr (in_instr),
   .busy     (busy)
);

// File: tb/test_interp_core.sv
module test_interp_core;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_instr = '0;
   logic       busy;
   logic [1:0] dbg_sel = '0;
   logic       dbg_we = 1'b0;
   logic [7:0] dbg_wdata = '0;
   logic [7:0] dbg_data;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [4];

   always #5 clk = ~clk;

   interp_core i_interp_core (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_instr(in_instr), .busy(busy), .dbg_sel(dbg_sel), .dbg_we(dbg_we),
      .dbg_wdata(dbg_wdata), .dbg_data(dbg_data)
   );

   function automatic logic [7:0] f_exec(input logic [1:0] op,
                                         input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p;
      p = 16'(a) * 16'(b);
      if (op == 2'b00) return a + b;
      return p[7:0];
   endfunction

   function automatic int f_stall(input logic [1:0] op);
      if (op == 2'b00) return 1;
      if (op == 2'b01) return 8;
      return 0;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      for (int r = 0; r < 4; r++) begin
         dbg_sel = 2'(r);
         #1;
         check(req, int'(dbg_data), int'(model[r]));
      end
   endtask

   task automatic dbg_write(input logic [1:0] sel, input logic [7:0] val);
      @(negedge clk);
      dbg_sel = sel; dbg_wdata = val; dbg_we = 1'b1;
      @(negedge clk);
      dbg_we = 1'b0;
      model[sel] = val;
   endtask

   task automatic issue(input logic [7:0] ins, input string req);
      int stall;
      logic [7:0] res;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      res = f_exec(ins[7:6], model[ins[3:2]], model[ins[1:0]]);
      in_instr = ins; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      stall = 0;
      while (!in_ready && stall < 50) begin
         check("R11", int'(busy), 1);
         stall++;
         @(negedge clk);
      end
      check({req, " stall"}, stall, f_stall(ins[7:6]));
      if (!ins[7]) model[ins[5:4]] = res;
      check_regs(req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int r = 0; r < 4; r++) model[r] = '0;
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R9 ready", int'(in_ready), 1);
      check("R11 busy", int'(busy), 0);
      check_regs("R9 reset regs");

      // R4 R10: load distinct values through the debug port
      dbg_write(2'b00, 8'h11);
      dbg_write(2'b01, 8'h22);
      dbg_write(2'b10, 8'hFF);
      dbg_write(2'b11, 8'h80);
      check_regs("R4 R10 load");

      issue({2'b00, 2'b00, 2'b10, 2'b11}, "R2 R1 add wrap");
      issue({2'b01, 2'b01, 2'b10, 2'b10}, "R3 mul trunc");
      issue({2'b01, 2'b11, 2'b11, 2'b01}, "R3 R8 mul alias");
      issue({2'b00, 2'b10, 2'b10, 2'b10}, "R8 add triple alias");
      issue({2'b10, 2'b00, 2'b01, 2'b10}, "R5 idle op 10");
      issue({2'b11, 2'b11, 2'b00, 2'b00}, "R5 idle op 11");

      // R10: debug write during MUL is ignored
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      begin
         logic [7:0] res;
         res = f_exec(2'b01, model[1], model[2]);
         in_instr = {2'b01, 2'b00, 2'b01, 2'b10}; in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         repeat (2) @(negedge clk);
         dbg_sel = 2'b11; dbg_wdata = 8'h5A; dbg_we = 1'b1;
         @(negedge clk);
         dbg_we = 1'b0;
         while (!in_ready) @(negedge clk);
         model[0] = res;
         check_regs("R10 busy write ignored");
      end

      // R7 R6: random mix
      for (int i = 0; i < 300; i++) begin
         if (($urandom % 5) == 0)
            dbg_write(2'($urandom), 8'($urandom));
         issue(8'($urandom), "R6 R7 random");
      end

      // R9: reset clears loaded state
      dbg_write(2'b01, 8'hC3);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int r = 0; r < 4; r++) model[r] = '0;
      check("R9 ready after reset", int'(in_ready), 1);
      check_regs("R9 reset clears");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule